// File: doc/BRIEF.md
# DMA Channel Pointer and Buffer-Wrap Unit

This block holds the address state of one DMA channel: a source pointer, a destination pointer and an offset into the channel's internal staging buffer. A load strobe captures a mode word and two start addresses. From then on the block applies per-beat completion pulses. A read-done pulse carries the byte count of a finished source read, and a write-done pulse carries the byte count of a finished destination write. Each pulse moves the pointers it concerns. The bus protocol, arbitration and the data itself are handled elsewhere.

The mode word has these fields:
- a single-address (fly-by) bit;
- a 2-bit direction code: 01 is memory to peripheral, 10 is peripheral to memory, 00 and 11 are the other directions;
- separate increment enables for the source and the destination;
- a 3-bit buffer-size code;
- the programmable low bit of a 3-bit transfer code.

Mode words that cannot be used raise a configuration-error flag. While that flag is set the block freezes all of its pointers.

In dual-address mode, source reads fill the staging buffer. The buffer offset then advances modulo a power-of-two size. In single-address mode the buffer is bypassed. Both kinds of pulse then advance the one pointer on the memory side of the transfer.

Top module: `dma_ptr_unit`

## Requirements
- R1: The buffer size is 64 bytes shifted left by the captured size code, so codes 0 to 5 give 64 to 2048 bytes. `buf_addr` always stays below the selected size while no configuration error is present.
- R2: Loading a size code of 110 or 111 sets `cfg_err` on the clock edge of the load.
- R3: In dual-address mode with no error, each `rd_done` beat advances `buf_addr` by `rd_bytes` modulo the buffer size. When the byte count through the buffer reaches the size, the offset returns to zero. `wr_done` does not move `buf_addr`.
- R4: In dual-address mode with no error, `src_addr` advances by `rd_bytes` on each `rd_done` when source increment is set. It stays fixed when source increment is clear.
- R5: In dual-address mode with no error, `dst_addr` advances by `wr_bytes` on each `wr_done` when destination increment is set. It stays fixed when destination increment is clear.
- R6: Loading fly-by = 1 with direction 00 or 11 sets `cfg_err`.
- R7: Loading fly-by = 1 with unequal increment enables sets `cfg_err`. In fly-by mode `buf_addr` never changes after the load.
- R8: While `xfer_active` is 1, `tcode` equals {1, 1, captured low bit}. While it is 0, `tcode` is 000.
- R9: On a `load` edge, `src_addr` and `dst_addr` take `start_src` and `start_dst`, `buf_addr` becomes 0, and the mode word is captured.
  - Load takes priority over done pulses in the same cycle.
  - Mode inputs have no effect between loads.
- R10: In legal fly-by mode, the memory-side pointer advances by the sum of the byte counts of all done pulses in the cycle. The memory side is the source for direction 01 and the destination for direction 10. It advances only when increment is enabled. The other pointer stays fixed.
- R11: While `cfg_err` is 1, done pulses change no pointer.
- R12: Addresses wrap modulo 2^32. For example, 0xFFFFFFF0 plus 32 gives 0x00000010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture mode word and start addresses |
| cfg_flyby | input | 1 | Single-address mode select |
| cfg_dir | input | 2 | Direction code (01 mem-to-periph, 10 periph-to-mem) |
| cfg_sinc | input | 1 | Source increment enable |
| cfg_dinc | input | 1 | Destination increment enable |
| cfg_wrap | input | 3 | Buffer size code |
| cfg_tc_lsb | input | 1 | Programmable low bit of the transfer code |
| start_src | input | 32 | Source start address |
| start_dst | input | 32 | Destination start address |
| rd_done | input | 1 | Source read beat completed |
| rd_bytes | input | 6 | Bytes in the completed read (1 to 32) |
| wr_done | input | 1 | Destination write beat completed |
| wr_bytes | input | 6 | Bytes in the completed write (1 to 32) |
| xfer_active | input | 1 | A DMA bus transaction is in progress |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| buf_addr | output | 11 | Current offset into the staging buffer |
| cfg_err | output | 1 | Captured mode word is illegal |
| tcode | output | 3 | Transfer code |

## Verification
The assertions check on every cycle the following behaviours:
- the buffer offset stays within the selected size;
- error detection for reserved size codes and illegal fly-by words;
- the values left by a load;
- the pointers holding when no pulse arrives;
- the frozen pointers under an error;
- the buffer staying still in fly-by mode;
- the fixed upper bits of the transfer code.

The exact increment amounts can only be shown by the bench's scenarios, which compare against a reference model. These cover:
- wrap-around at the exact buffer boundary;
- the choice of memory-side pointer in each fly-by direction;
- the summing of both pulses in one cycle;
- 32-bit address overflow.

// File: rtl/dma_ptr_pkg.sv
package dma_ptr_pkg;

  typedef enum logic [1:0] {
    DIR_MEM_MEM = 2'b00,
    DIR_M2P     = 2'b01,
    DIR_P2M     = 2'b10,
    DIR_OTHER   = 2'b11
  } dir_e;

  typedef struct packed {
    logic       flyby;
    dir_e       dir;
    logic       sinc;
    logic       dinc;
    logic [2:0] wrap;
    logic       tc_lsb;
  } mode_t;

  // A mode word is unusable if its size code exceeds the supported range,
  // or if single-address mode is combined with a direction or increment
  // pairing that has no single memory side.
  function automatic logic mode_illegal(mode_t m, int max_code);
    logic bad_size, bad_dir, bad_inc;
    bad_size = (int'(m.wrap) > max_code);
    bad_dir  = m.flyby && !(m.dir == DIR_M2P || m.dir == DIR_P2M);
    bad_inc  = m.flyby && (m.sinc != m.dinc);
    return bad_size || bad_dir || bad_inc;
  endfunction

endpackage

// File: rtl/dma_mode_reg.sv
module dma_mode_reg
  import dma_ptr_pkg::*;
#(
  parameter int WRAP_MAX_CODE = 5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  mode_t mode_in,
  output mode_t mode_q,
  output logic  err_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      err_q  <= 1'b0;
    end else if (load) begin
      mode_q <= mode_in;
      err_q  <= mode_illegal(mode_in, WRAP_MAX_CODE);
    end
  end

endmodule

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start,
  input  logic              step_a,
  input  logic [CNT_W-1:0]  bytes_a,
  input  logic              step_b,
  input  logic [CNT_W-1:0]  bytes_b,
  output logic [ADDR_W-1:0] ptr
);

  function automatic logic [ADDR_W-1:0] advance(
    logic [ADDR_W-1:0] base,
    logic ea, logic [CNT_W-1:0] na,
    logic eb, logic [CNT_W-1:0] nb);
    logic [ADDR_W-1:0] da, db;
    da = ea ? ADDR_W'(na) : '0;
    db = eb ? ADDR_W'(nb) : '0;
    return base + da + db;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (load)
      ptr <= start;
    else if (step_a || step_b)
      ptr <= advance(ptr, step_a, bytes_a, step_b, bytes_b);
  end

endmodule

// File: rtl/dma_buf_ptr.sv
module dma_buf_ptr #(
  parameter int CNT_W         = 6,
  parameter int WRAP_BASE_LG  = 6,
  parameter int WRAP_MAX_CODE = 5,
  localparam int BUF_W        = WRAP_BASE_LG + WRAP_MAX_CODE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] bytes,
  input  logic [2:0]       wrap_code,
  output logic [BUF_W-1:0] offset,
  output logic             wrapped
);

  // Size of the buffer in bytes, one bit wider than the offset so the
  // largest size is representable.
  function automatic logic [BUF_W:0] buf_size(logic [2:0] code);
    int lg;
    lg = WRAP_BASE_LG + int'(code);
    if (lg > BUF_W) lg = BUF_W;
    return (BUF_W+1)'(1) << lg;
  endfunction

  logic [BUF_W:0] sum;
  logic [BUF_W:0] size;
  logic [BUF_W:0] next;

  always_comb begin
    size    = buf_size(wrap_code);
    sum     = {1'b0, offset} + (BUF_W+1)'(bytes);
    next    = sum & (size - 1'b1);
    wrapped = step && (sum >= size);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      offset <= '0;
    else if (load)
      offset <= '0;
    else if (step)
      offset <= next[BUF_W-1:0];
  end

endmodule

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit
  import dma_ptr_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int CNT_W         = 6,
  parameter int WRAP_BASE_LG  = 6,
  parameter int WRAP_MAX_CODE = 5,
  localparam int BUF_W        = WRAP_BASE_LG + WRAP_MAX_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cfg_flyby,
  input  logic [1:0]        cfg_dir,
  input  logic              cfg_sinc,
  input  logic              cfg_dinc,
  input  logic [2:0]        cfg_wrap,
  input  logic              cfg_tc_lsb,
  input  logic [ADDR_W-1:0] start_src,
  input  logic [ADDR_W-1:0] start_dst,
  input  logic              rd_done,
  input  logic [CNT_W-1:0]  rd_bytes,
  input  logic              wr_done,
  input  logic [CNT_W-1:0]  wr_bytes,
  input  logic              xfer_active,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [BUF_W-1:0]  buf_addr,
  output logic              cfg_err,
  output logic [2:0]        tcode
);

  mode_t mode_in, mode_q;

  always_comb begin
    mode_in        = '0;
    mode_in.flyby  = cfg_flyby;
    mode_in.dir    = dir_e'(cfg_dir);
    mode_in.sinc   = cfg_sinc;
    mode_in.dinc   = cfg_dinc;
    mode_in.wrap   = cfg_wrap;
    mode_in.tc_lsb = cfg_tc_lsb;
  end

  dma_mode_reg #(.WRAP_MAX_CODE(WRAP_MAX_CODE)) u_mode (
    .clk(clk), .rst_n(rst_n), .load(load),
    .mode_in(mode_in), .mode_q(mode_q), .err_q(cfg_err)
  );

  // Named per-cycle events, visible to the checker.
  logic upd_ok, fly_q, fly_src_side, fly_dst_side;
  logic src_step_a, src_step_b, dst_step_a, dst_step_b;
  logic buf_step, buf_wrapped;
  logic [CNT_W-1:0] dst_bytes_a;

  always_comb begin
    upd_ok       = !load && !cfg_err;
    fly_q        = mode_q.flyby;
    fly_src_side = fly_q && (mode_q.dir == DIR_M2P);
    fly_dst_side = fly_q && (mode_q.dir == DIR_P2M);

    if (fly_q) begin
      src_step_a  = upd_ok && fly_src_side && mode_q.sinc && rd_done;
      src_step_b  = upd_ok && fly_src_side && mode_q.sinc && wr_done;
      dst_step_a  = upd_ok && fly_dst_side && mode_q.dinc && rd_done;
      dst_step_b  = upd_ok && fly_dst_side && mode_q.dinc && wr_done;
      dst_bytes_a = rd_bytes;
    end else begin
      src_step_a  = upd_ok && mode_q.sinc && rd_done;
      src_step_b  = 1'b0;
      dst_step_a  = upd_ok && mode_q.dinc && wr_done;
      dst_step_b  = 1'b0;
      dst_bytes_a = wr_bytes;
    end

    buf_step = upd_ok && !fly_q && rd_done;
  end

  dma_addr_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load), .start(start_src),
    .step_a(src_step_a), .bytes_a(rd_bytes),
    .step_b(src_step_b), .bytes_b(wr_bytes),
    .ptr(src_addr)
  );

  dma_addr_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(load), .start(start_dst),
    .step_a(dst_step_a), .bytes_a(dst_bytes_a),
    .step_b(dst_step_b), .bytes_b(wr_bytes),
    .ptr(dst_addr)
  );

  dma_buf_ptr #(
    .CNT_W(CNT_W), .WRAP_BASE_LG(WRAP_BASE_LG), .WRAP_MAX_CODE(WRAP_MAX_CODE)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .load(load), .step(buf_step),
    .bytes(rd_bytes), .wrap_code(mode_q.wrap),
    .offset(buf_addr), .wrapped(buf_wrapped)
  );

  assign tcode = xfer_active ? {2'b11, mode_q.tc_lsb} : 3'b000;

endmodule

// File: rtl/dma_ptr_unit_chk.sv
module dma_ptr_unit_chk #(
  parameter int ADDR_W       = 32,
  parameter int BUF_W        = 11,
  parameter int WRAP_BASE_LG = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              cfg_flyby,
  input logic [1:0]        cfg_dir,
  input logic              cfg_sinc,
  input logic              cfg_dinc,
  input logic [2:0]        cfg_wrap,
  input logic [ADDR_W-1:0] start_src,
  input logic [ADDR_W-1:0] start_dst,
  input logic              rd_done,
  input logic              wr_done,
  input logic              xfer_active,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [BUF_W-1:0]  buf_addr,
  input logic              cfg_err,
  input logic [2:0]        tcode,
  input logic              fly_q,
  input logic [2:0]        wrap_q,
  input logic              buf_wrapped
);

  assert_buf_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err |-> ((32'(buf_addr) >> (WRAP_BASE_LG + int'(wrap_q))) == 0));

  assert_reserved_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg_wrap[2:1] == 2'b11) |=> cfg_err);

  assert_wrap_to_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wrapped |=> (buf_addr < BUF_W'(32)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !rd_done && !wr_done) |=>
      ($stable(src_addr) && $stable(dst_addr) && $stable(buf_addr)));

  assert_flyby_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg_flyby && (cfg_dir == 2'b00 || cfg_dir == 2'b11)) |=> cfg_err);

  assert_flyby_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg_flyby && (cfg_sinc != cfg_dinc)) |=> cfg_err);

  assert_flyby_buf_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && fly_q) |=> $stable(buf_addr));

  assert_tcode_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |-> (tcode[2:1] == 2'b11));

  assert_tcode_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> (tcode == 3'b000));

  assert_load_values_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (src_addr == $past(start_src) && dst_addr == $past(start_dst)
              && buf_addr == '0));

  assert_err_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !load) |=>
      ($stable(src_addr) && $stable(dst_addr) && $stable(buf_addr)));

endmodule

bind dma_ptr_unit dma_ptr_unit_chk #(
  .ADDR_W(ADDR_W), .BUF_W(BUF_W), .WRAP_BASE_LG(WRAP_BASE_LG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .cfg_flyby(cfg_flyby),
  .cfg_dir(cfg_dir), .cfg_sinc(cfg_sinc), .cfg_dinc(cfg_dinc),
  .cfg_wrap(cfg_wrap), .start_src(start_src), .start_dst(start_dst),
  .rd_done(rd_done), .wr_done(wr_done), .xfer_active(xfer_active),
  .src_addr(src_addr), .dst_addr(dst_addr), .buf_addr(buf_addr),
  .cfg_err(cfg_err), .tcode(tcode), .fly_q(fly_q), .wrap_q(mode_q.wrap),
  .buf_wrapped(buf_wrapped)
);

// File: tb/sim_dma_ptr_unit.sv
module sim_dma_ptr_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic        cfg_flyby = 1'b0;
  logic [1:0]  cfg_dir = 2'b00;
  logic        cfg_sinc = 1'b0;
  logic        cfg_dinc = 1'b0;
  logic [2:0]  cfg_wrap = 3'd0;
  logic        cfg_tc_lsb = 1'b0;
  logic [31:0] start_src = '0;
  logic [31:0] start_dst = '0;
  logic        rd_done = 1'b0;
  logic [5:0]  rd_bytes = 6'd1;
  logic        wr_done = 1'b0;
  logic [5:0]  wr_bytes = 6'd1;
  logic        xfer_active = 1'b0;
  logic [31:0] src_addr, dst_addr;
  logic [10:0] buf_addr;
  logic        cfg_err;
  logic [2:0]  tcode;

  dma_ptr_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference state
  logic [31:0] m_src = '0, m_dst = '0, m_buf = '0;
  logic m_fly = 0, m_si = 0, m_di = 0, m_tc = 0, m_err = 0;
  logic [1:0] m_dir = 0;
  logic [2:0] m_wrap = 0;

  function automatic logic ref_err(logic f, logic [1:0] d, logic si, logic di,
                                   logic [2:0] w);
    if (w >= 3'd6) return 1'b1;
    if (f && (d == 2'b00 || d == 2'b11)) return 1'b1;
    if (f && si != di) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] ref_size(logic [2:0] w);
    return 32'd64 * (32'd1 << w);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] tot;
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_buf = 0; m_fly = 0; m_dir = 0;
      m_si = 0; m_di = 0; m_wrap = 0; m_tc = 0; m_err = 0;
    end else if (load) begin
      m_src = start_src; m_dst = start_dst; m_buf = 0;
      m_fly = cfg_flyby; m_dir = cfg_dir; m_si = cfg_sinc; m_di = cfg_dinc;
      m_wrap = cfg_wrap; m_tc = cfg_tc_lsb;
      m_err = ref_err(cfg_flyby, cfg_dir, cfg_sinc, cfg_dinc, cfg_wrap);
    end else if (!m_err) begin
      if (m_fly) begin
        tot = (rd_done ? 32'(rd_bytes) : 0) + (wr_done ? 32'(wr_bytes) : 0);
        if (m_si && m_dir == 2'b01) m_src = m_src + tot;
        if (m_di && m_dir == 2'b10) m_dst = m_dst + tot;
      end else begin
        if (rd_done && m_si) m_src = m_src + 32'(rd_bytes);
        if (wr_done && m_di) m_dst = m_dst + 32'(wr_bytes);
        if (rd_done) m_buf = (m_buf + 32'(rd_bytes)) % ref_size(m_wrap);
      end
    end
  endtask

  // One clock: model follows the edge, outputs compared at the falling edge.
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " src R4"}, src_addr, m_src);
    chk({tag, " dst R5"}, dst_addr, m_dst);
    chk({tag, " buf R3"}, 32'(buf_addr), m_buf);
    chk({tag, " err R2"}, 32'(cfg_err), 32'(m_err));
    chk({tag, " tcode R8"}, 32'(tcode), xfer_active ? 32'({2'b11, m_tc}) : 32'd0);
  endtask

  task automatic do_load(input logic f, input logic [1:0] d, input logic si,
                         input logic di, input logic [2:0] w, input logic tc,
                         input logic [31:0] s, input logic [31:0] t);
    load = 1; cfg_flyby = f; cfg_dir = d; cfg_sinc = si; cfg_dinc = di;
    cfg_wrap = w; cfg_tc_lsb = tc; start_src = s; start_dst = t;
    tick();
    load = 0;
    // Mode inputs scrambled after the load must have no effect (R9).
    cfg_flyby = ~f; cfg_wrap = ~w; cfg_sinc = ~si;
  endtask

  task automatic beat(input logic r, input logic [5:0] rb,
                      input logic w, input logic [5:0] wb);
    rd_done = r; rd_bytes = rb; wr_done = w; wr_bytes = wb;
    tick();
    rd_done = 0; wr_done = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    @(negedge clk);
    tick(); tick();
    check_all("reset R9");
    rst_n = 1;
    tick();

    // R1/R3: smallest buffer wraps exactly at 64 bytes
    do_load(0, 2'b00, 1, 1, 3'd0, 1, 32'h1000, 32'h2000);
    check_all("load R9");
    beat(1, 6'd32, 0, 6'd1);
    chk("R3 half buffer", 32'(buf_addr), 32'd32);
    beat(1, 6'd32, 1, 6'd8);
    chk("R3 wrap to zero", 32'(buf_addr), 32'd0);
    chk("R5 dst advance", dst_addr, 32'h2008);
    chk("R4 src advance", src_addr, 32'h1040);

    // R12: address overflow
    do_load(0, 2'b00, 1, 0, 3'd5, 0, 32'hFFFF_FFF0, 32'h0000_0100);
    beat(1, 6'd32, 1, 6'd4);
    chk("R12 src wraps 2^32", src_addr, 32'h0000_0010);
    chk("R5 dst fixed", dst_addr, 32'h0000_0100);
    chk("R1 largest buffer", 32'(buf_addr), 32'd32);

    // R10: fly-by, memory side is source for dir 01, both pulses summed
    do_load(1, 2'b01, 1, 1, 3'd2, 1, 32'h4000, 32'h8000);
    beat(1, 6'd4, 1, 6'd8);
    chk("R10 src sum", src_addr, 32'h400C);
    chk("R10 dst fixed", dst_addr, 32'h8000);
    chk("R7 buf fixed", 32'(buf_addr), 32'd0);
    // dir 10: destination side
    do_load(1, 2'b10, 1, 1, 3'd1, 0, 32'h4000, 32'h8000);
    beat(1, 6'd16, 0, 6'd1);
    chk("R10 dst side", dst_addr, 32'h8010);
    chk("R10 src fixed", src_addr, 32'h4000);

    // R2/R6/R7/R11: illegal words freeze pointers
    do_load(0, 2'b00, 1, 1, 3'd6, 0, 32'h10, 32'h20);
    chk("R2 reserved 110", 32'(cfg_err), 32'd1);
    beat(1, 6'd8, 1, 6'd8);
    chk("R11 frozen src", src_addr, 32'h10);
    do_load(1, 2'b11, 1, 1, 3'd0, 0, 32'h10, 32'h20);
    chk("R6 bad dir", 32'(cfg_err), 32'd1);
    do_load(1, 2'b01, 1, 0, 3'd0, 0, 32'h10, 32'h20);
    chk("R7 bad inc", 32'(cfg_err), 32'd1);

    // R9: load wins over a simultaneous done pulse
    load = 1; cfg_flyby = 0; cfg_dir = 0; cfg_sinc = 1; cfg_dinc = 1;
    cfg_wrap = 3'd3; start_src = 32'h500; start_dst = 32'h600;
    rd_done = 1; rd_bytes = 6'd12;
    tick();
    load = 0; rd_done = 0;
    chk("R9 load priority", src_addr, 32'h500);
    chk("R9 load buf zero", 32'(buf_addr), 32'd0);

    // R8 transfer code
    xfer_active = 1;
    #1;
    chk("R8 tcode active", 32'(tcode), 32'({2'b11, m_tc}));
    xfer_active = 0;

    // Random phases
    for (int ph = 0; ph < 40; ph++) begin
      logic f, si, di;
      logic [1:0] d;
      logic [2:0] w;
      f  = ($urandom % 3) == 0;
      d  = 2'($urandom);
      si = 1'($urandom);
      di = (f && ($urandom % 4 != 0)) ? si : 1'($urandom);
      w  = ($urandom % 8 == 0) ? 3'(6 + $urandom % 2) : 3'($urandom % 6);
      do_load(f, d, si, di, w, 1'($urandom), $urandom, $urandom);
      check_all("rand load");
      for (int b = 0; b < 60; b++) begin
        xfer_active = 1'($urandom);
        rd_done = 1'($urandom); rd_bytes = 6'(1 + $urandom % 32);
        wr_done = 1'($urandom); wr_bytes = 6'(1 + $urandom % 32);
        tick();
        check_all("rand beat");
      end
      rd_done = 0; wr_done = 0; xfer_active = 0;
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule